// File: doc/BRIEF.md
# Frame-Synchronised Serial Audio Receiver

This block turns one serial audio data line into parallel words. It watches a bit clock and a frame sync that are already sampled into the system clock domain. The sync either comes from a local generator or from an external master. A rising edge of the frame sync, seen at a rising bit clock edge, opens a frame, and the bit taken at that same edge is the first data bit. From there the block shifts bits in MSB first. Each word is right-aligned with zeros above it, and it is pushed into an 8-entry FIFO that software or a DMA engine drains through a simple read port.

One frame holds 1 to 32 word slots. The first slot has its own width setting and the other slots share a second one. Widths are given as the bit count minus one, and any value below 7 is raised to 7. When the sync comes from an external master, the block counts the bits between sync edges and compares the count with the frame length that the settings imply. A sync that comes early or late raises a sticky error, and the framing restarts at that edge.

Top module: `tdm_rx`

## Requirements
- R1: After reset the FIFO level is 0, and the watermark, full, DMA request, overrun and sync-error outputs are all 0.
- R2: Data is sampled on rising bit clock edges, MSB first. A completed word appears on rd_data_o right-aligned, with its upper bits zero, for widths up to 32 bits.
- R3: A frame starts at a bit clock rising edge where fsync_i is 1 and was 0 at the previous rising edge. That bit is the first bit of slot 0. Bits that arrive before the first frame start are not captured.
- R4: Slot 0 is first_wm1_i+1 bits wide and every later slot is word_wm1_i+1 bits wide. A setting below 7 is treated as 7, so a word is always at least 8 bits.
- R5: A frame holds slots_m1_i+1 slots. Bits after the last slot and before the next frame start are discarded.
- R6: The FIFO keeps 8 words in arrival order, and level_o gives the count. A read (rd_en_i) of an empty FIFO changes nothing.
- R7: wm_o is 1 when level_o >= watermark_i. full_o is 1 when level_o is 8. dma_req_o is 1 when either of them is 1.
- R8: A word completed while the FIFO is full (and no read happens in that cycle) is dropped and the stored words are kept. ovr_o is then set and stays at 1 until ovr_clr_i is pulsed.
- R9: With ext_sync_i at 1, a frame start whose bit count since the previous frame start differs from the frame length (the slot 0 width plus slots_m1_i times the other width) sets serr_o. The frame restarts at that edge, and serr_o stays at 1 until serr_clr_i is pulsed.
- R10: With ext_sync_i at 0, frame starts at any bit count never set serr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sync_i | input | 1 | 1: sync comes from an external master and its length is checked |
| first_wm1_i | input | 5 | Slot 0 width minus one |
| word_wm1_i | input | 5 | Width minus one for the other slots |
| slots_m1_i | input | 5 | Slots per frame minus one |
| watermark_i | input | 4 | FIFO level threshold for wm_o |
| bclk_i | input | 1 | Bit clock, sampled by clk |
| fsync_i | input | 1 | Frame sync, sampled by clk |
| sdata_i | input | 1 | Serial data |
| rd_en_i | input | 1 | Pop the head word |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| serr_clr_i | input | 1 | Clear the sync-error flag |
| rd_data_o | output | 32 | Head word of the FIFO |
| level_o | output | 4 | Words held in the FIFO |
| wm_o | output | 1 | Watermark reached |
| full_o | output | 1 | FIFO full |
| dma_req_o | output | 1 | Transfer request |
| ovr_o | output | 1 | Sticky overrun |
| serr_o | output | 1 | Sticky sync error |

## Verification
The bench sends frames whose next sync comes exactly one bit early, exactly one bit late and exactly on time. A design that counted bits off by one would flag the good frame or miss the bad ones. A design that did not resynchronise would keep flagging after the error was cleared. The bench also fills the FIFO past 8 words and checks that the oldest eight come out unchanged, which catches overwriting or pointer slip. Other cases are a 24-bit first slot before 8-bit slots, a width setting below the floor, bits beyond the last slot, and full 32-bit words. A design that mixed up the two widths, ignored the clamp or kept capturing past the last slot would return wrong words or a wrong level.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int RX_WORD_MAX   = 32;
    localparam int RX_SLOT_MAX   = 32;
    localparam int RX_FIFO_DEPTH = 8;
    localparam int RX_MIN_WM1    = 7;

    typedef struct packed {
        logic ovr;
        logic serr;
    } rx_flags_t;
endpackage

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int WORD_MAX = tdm_rx_pkg::RX_WORD_MAX,
    parameter int SLOT_MAX = tdm_rx_pkg::RX_SLOT_MAX
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ext_sync_i,
    input  logic [$clog2(WORD_MAX)-1:0] first_wm1_i,
    input  logic [$clog2(WORD_MAX)-1:0] word_wm1_i,
    input  logic [$clog2(SLOT_MAX)-1:0] slots_m1_i,
    input  logic                        bclk_i,
    input  logic                        fsync_i,
    input  logic                        sdata_i,
    output logic [WORD_MAX-1:0]         word_o,
    output logic                        word_valid_o,
    output logic                        serr_o
);
    localparam int WBW = $clog2(WORD_MAX);
    localparam int SBW = $clog2(SLOT_MAX);
    localparam int FLW = $clog2(WORD_MAX * SLOT_MAX) + 1;

    typedef struct packed {
        logic                bclk_prev;
        logic                fs_prev;
        logic                active;
        logic [FLW-1:0]      bitcnt;
        logic [SBW:0]        slot;
        logic [WBW-1:0]      bit_in_word;
        logic [WORD_MAX-1:0] shift;
        logic [WORD_MAX-1:0] word;
        logic                word_valid;
        logic                serr;
    } deser_t;

    deser_t q, d;

    logic                bclk_rise;
    logic                fs_start;
    logic [WBW-1:0]      first_eff;
    logic [WBW-1:0]      word_eff;
    logic [WBW-1:0]      cur_m1;
    logic [FLW-1:0]      frame_len;
    logic [WORD_MAX-1:0] shifted;

    always_comb begin
        first_eff = (first_wm1_i < WBW'(tdm_rx_pkg::RX_MIN_WM1)) ? WBW'(tdm_rx_pkg::RX_MIN_WM1) : first_wm1_i;
        word_eff  = (word_wm1_i  < WBW'(tdm_rx_pkg::RX_MIN_WM1)) ? WBW'(tdm_rx_pkg::RX_MIN_WM1) : word_wm1_i;
        cur_m1    = (q.slot == '0) ? first_eff : word_eff;
        frame_len = FLW'(first_eff) + FLW'(1)
                  + FLW'(slots_m1_i) * (FLW'(word_eff) + FLW'(1));
        bclk_rise = bclk_i & ~q.bclk_prev;
        fs_start  = fsync_i & ~q.fs_prev;
        shifted   = {q.shift[WORD_MAX-2:0], sdata_i};

        d            = q;
        d.bclk_prev  = bclk_i;
        d.word_valid = 1'b0;
        d.serr       = 1'b0;

        if (bclk_rise) begin
            d.fs_prev = fsync_i;
            if (fs_start) begin
                if (q.active && ext_sync_i && (q.bitcnt != frame_len)) begin
                    d.serr = 1'b1;
                end
                d.active      = 1'b1;
                d.bitcnt      = FLW'(1);
                d.slot        = '0;
                d.bit_in_word = WBW'(1);
                d.shift       = {{(WORD_MAX-1){1'b0}}, sdata_i};
            end else if (q.active) begin
                if (q.bitcnt != '1) begin
                    d.bitcnt = q.bitcnt + FLW'(1);
                end
                if (q.slot <= {1'b0, slots_m1_i}) begin
                    if (q.bit_in_word == cur_m1) begin
                        d.word        = shifted;
                        d.word_valid  = 1'b1;
                        d.shift       = '0;
                        d.bit_in_word = '0;
                        d.slot        = q.slot + 1'b1;
                    end else begin
                        d.shift       = shifted;
                        d.bit_in_word = q.bit_in_word + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_o       = q.word;
    assign word_valid_o = q.word_valid;
    assign serr_o       = q.serr;
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
    parameter int DEPTH = tdm_rx_pkg::RX_FIFO_DEPTH,
    parameter int W     = tdm_rx_pkg::RX_WORD_MAX
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               data_i,
    input  logic                       pop_i,
    output logic [W-1:0]               data_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  pop_ok, push_ok;

    always_comb begin
        pop_ok  = pop_i && (q.cnt != '0);
        push_ok = push_i && ((q.cnt != CW'(DEPTH)) || pop_ok);
        d = q;
        if (push_ok) begin
            d.mem[q.wp] = data_i;
            d.wp        = q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.mem[q.rp];
    assign count_o = q.cnt;
    assign ovf_o   = push_i && !push_ok;
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
    parameter int WORD_MAX   = tdm_rx_pkg::RX_WORD_MAX,
    parameter int SLOT_MAX   = tdm_rx_pkg::RX_SLOT_MAX,
    parameter int FIFO_DEPTH = tdm_rx_pkg::RX_FIFO_DEPTH
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ext_sync_i,
    input  logic [$clog2(WORD_MAX)-1:0]     first_wm1_i,
    input  logic [$clog2(WORD_MAX)-1:0]     word_wm1_i,
    input  logic [$clog2(SLOT_MAX)-1:0]     slots_m1_i,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0] watermark_i,
    input  logic                            bclk_i,
    input  logic                            fsync_i,
    input  logic                            sdata_i,
    input  logic                            rd_en_i,
    input  logic                            ovr_clr_i,
    input  logic                            serr_clr_i,
    output logic [WORD_MAX-1:0]             rd_data_o,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] level_o,
    output logic                            wm_o,
    output logic                            full_o,
    output logic                            dma_req_o,
    output logic                            ovr_o,
    output logic                            serr_o
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [WORD_MAX-1:0] w_data;
    logic                w_valid;
    logic                serr_pulse;
    logic                ovf_pulse;

    tdm_rx_pkg::rx_flags_t flags_q, flags_d;

    tdm_rx_deser #(.WORD_MAX(WORD_MAX), .SLOT_MAX(SLOT_MAX)) u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_sync_i   (ext_sync_i),
        .first_wm1_i  (first_wm1_i),
        .word_wm1_i   (word_wm1_i),
        .slots_m1_i   (slots_m1_i),
        .bclk_i       (bclk_i),
        .fsync_i      (fsync_i),
        .sdata_i      (sdata_i),
        .word_o       (w_data),
        .word_valid_o (w_valid),
        .serr_o       (serr_pulse)
    );

    tdm_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_MAX)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (w_valid),
        .data_i  (w_data),
        .pop_i   (rd_en_i),
        .data_o  (rd_data_o),
        .count_o (level_o),
        .ovf_o   (ovf_pulse)
    );

    always_comb begin
        flags_d      = flags_q;
        flags_d.ovr  = (flags_q.ovr  & ~ovr_clr_i)  | ovf_pulse;
        flags_d.serr = (flags_q.serr & ~serr_clr_i) | serr_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign wm_o      = (level_o >= watermark_i);
    assign full_o    = (level_o == CW'(FIFO_DEPTH));
    assign dma_req_o = wm_o | full_o;
    assign ovr_o     = flags_q.ovr;
    assign serr_o    = flags_q.serr;
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
    parameter int DEPTH = tdm_rx_pkg::RX_FIFO_DEPTH
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       w_valid,
    input logic                       rd_en_i,
    input logic                       ovr_clr_i,
    input logic                       serr_clr_i,
    input logic [$clog2(DEPTH+1)-1:0] level_o,
    input logic                       full_o,
    input logic                       ovr_o,
    input logic                       serr_o
);
    localparam int CW = $clog2(DEPTH + 1);

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= CW'(DEPTH));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0 && rd_en_i && !w_valid) |=> (level_o == '0));

    assert_drop_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && w_valid && !rd_en_i) |=> (level_o == CW'(DEPTH)));

    assert_drop_sets_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && w_valid && !rd_en_i) |=> ovr_o);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !ovr_clr_i) |=> ovr_o);

    assert_serr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_o && !serr_clr_i) |=> serr_o);

    assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |=> !w_valid);
endmodule

bind tdm_rx tdm_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .w_valid    (w_valid),
    .rd_en_i    (rd_en_i),
    .ovr_clr_i  (ovr_clr_i),
    .serr_clr_i (serr_clr_i),
    .level_o    (level_o),
    .full_o     (full_o),
    .ovr_o      (ovr_o),
    .serr_o     (serr_o)
);

// File: tb/tdm_rx_tb.sv
module tdm_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_sync_i = 1'b0;
    logic [4:0]  first_wm1_i = 5'd15;
    logic [4:0]  word_wm1_i = 5'd15;
    logic [4:0]  slots_m1_i = 5'd1;
    logic [3:0]  watermark_i = 4'd4;
    logic        bclk_i = 1'b0;
    logic        fsync_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        ovr_clr_i = 1'b0;
    logic        serr_clr_i = 1'b0;
    logic [31:0] rd_data_o;
    logic [3:0]  level_o;
    logic        wm_o, full_o, dma_req_o, ovr_o, serr_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tdm_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ext_sync_i(ext_sync_i),
        .first_wm1_i(first_wm1_i), .word_wm1_i(word_wm1_i),
        .slots_m1_i(slots_m1_i), .watermark_i(watermark_i),
        .bclk_i(bclk_i), .fsync_i(fsync_i), .sdata_i(sdata_i),
        .rd_en_i(rd_en_i), .ovr_clr_i(ovr_clr_i), .serr_clr_i(serr_clr_i),
        .rd_data_o(rd_data_o), .level_o(level_o), .wm_o(wm_o),
        .full_o(full_o), .dma_req_o(dma_req_o), .ovr_o(ovr_o), .serr_o(serr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic fs);
        @(negedge clk);
        bclk_i  = 1'b0;
        sdata_i = b;
        fsync_i = fs;
        repeat (4) @(negedge clk);
        bclk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input logic sync);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(v[i], sync && (i == n - 1));
        end
    endtask

    task automatic send_frame16(input logic [15:0] a, input logic [15:0] b);
        send_bits({16'h0, a}, 16, 1'b1);
        send_bits({16'h0, b}, 16, 1'b0);
    endtask

    task automatic pop_check(input string tag, input logic [31:0] exp);
        @(negedge clk);
        check(tag, rd_data_o, exp);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        ovr_clr_i  = 1'b1;
        serr_clr_i = 1'b1;
        @(negedge clk);
        ovr_clr_i  = 1'b0;
        serr_clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 level", 32'(level_o), 0);
        check("R1 wm", 32'(wm_o), 0);
        check("R1 full", 32'(full_o), 0);
        check("R1 dma", 32'(dma_req_o), 0);
        check("R1 ovr", 32'(ovr_o), 0);
        check("R1 serr", 32'(serr_o), 0);
    endtask

    task automatic t_basic();
        ext_sync_i = 0; first_wm1_i = 15; word_wm1_i = 15; slots_m1_i = 1;
        send_bits(32'hFFFF, 12, 1'b0);
        @(negedge clk);
        check("R3 no capture before sync", 32'(level_o), 0);
        send_frame16(16'hA5C3, 16'h1234);
        @(negedge clk);
        check("R3 level after frame", 32'(level_o), 2);
        pop_check("R2 word0 msb first", 32'h0000A5C3);
        pop_check("R2 word1", 32'h00001234);
    endtask

    task automatic t_widths();
        first_wm1_i = 23; word_wm1_i = 3; slots_m1_i = 2;
        send_bits(32'hABCDEF, 24, 1'b1);
        send_bits(32'h5A, 8, 1'b0);
        send_bits(32'hC3, 8, 1'b0);
        send_bits(32'hFF, 8, 1'b0);
        @(negedge clk);
        check("R5 extra bits dropped", 32'(level_o), 3);
        pop_check("R4 first slot 24b", 32'h00ABCDEF);
        pop_check("R4 clamped 8b slot1", 32'h0000005A);
        pop_check("R4 clamped 8b slot2", 32'h000000C3);
    endtask

    task automatic t_ext_sync();
        ext_sync_i = 1; first_wm1_i = 15; word_wm1_i = 15; slots_m1_i = 1;
        send_frame16(16'h1111, 16'h2222);
        clear_flags();
        pop_check("R9 f1 w0", 32'h1111);
        pop_check("R9 f1 w1", 32'h2222);
        send_frame16(16'h3333, 16'h4444);
        check("R9 on-time sync no error", 32'(serr_o), 0);
        pop_check("R9 f2 w0", 32'h3333);
        pop_check("R9 f2 w1", 32'h4444);
        send_bits(32'h5555, 16, 1'b1);
        send_bits(32'h7FFF, 15, 1'b0);
        send_frame16(16'h6666, 16'h7777);
        check("R9 early sync flagged", 32'(serr_o), 1);
        check("R9 partial word dropped", 32'(level_o), 3);
        pop_check("R9 short w0", 32'h5555);
        pop_check("R9 resync w0", 32'h6666);
        pop_check("R9 resync w1", 32'h7777);
        clear_flags();
        check("R9 cleared", 32'(serr_o), 0);
        send_frame16(16'h8888, 16'h9999);
        check("R9 counter resynced", 32'(serr_o), 0);
        pop_check("R9 f4 w0", 32'h8888);
        pop_check("R9 f4 w1", 32'h9999);
        send_bits(32'h1, 1, 1'b0);
        send_frame16(16'hAAAA, 16'hBBBB);
        check("R9 late sync flagged", 32'(serr_o), 1);
        pop_check("R9 f5 w0", 32'hAAAA);
        pop_check("R9 f5 w1", 32'hBBBB);
        clear_flags();
    endtask

    task automatic t_local_no_check();
        ext_sync_i = 0;
        send_bits(32'h1234, 16, 1'b1);
        send_frame16(16'hCAFE, 16'hBEEF);
        check("R10 local mode no error", 32'(serr_o), 0);
        pop_check("R10 w0", 32'h1234);
        pop_check("R10 w1", 32'hCAFE);
        pop_check("R10 w2", 32'hBEEF);
    endtask

    task automatic t_fifo();
        ext_sync_i = 0; first_wm1_i = 7; word_wm1_i = 7; slots_m1_i = 9;
        watermark_i = 4;
        for (int i = 0; i < 10; i++) begin
            send_bits(32'h10 + 32'(i), 8, i == 0);
            @(negedge clk);
            if (i == 2) begin
                check("R7 below watermark", 32'(wm_o), 0);
                check("R7 no dma below", 32'(dma_req_o), 0);
            end
            if (i == 3) begin
                check("R7 watermark reached", 32'(wm_o), 1);
                check("R7 dma at watermark", 32'(dma_req_o), 1);
            end
            if (i == 7) begin
                check("R7 full", 32'(full_o), 1);
                check("R8 no ovr yet", 32'(ovr_o), 0);
            end
            if (i == 8) begin
                check("R8 ovr set", 32'(ovr_o), 1);
                check("R8 level held", 32'(level_o), 8);
            end
        end
        for (int i = 0; i < 8; i++) begin
            pop_check("R8 kept contents", 32'h10 + 32'(i));
        end
        @(negedge clk);
        check("R6 empty", 32'(level_o), 0);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        @(negedge clk);
        check("R6 read on empty ignored", 32'(level_o), 0);
        check("R8 ovr sticky", 32'(ovr_o), 1);
        clear_flags();
        check("R8 ovr cleared", 32'(ovr_o), 0);
    endtask

    task automatic t_wide();
        first_wm1_i = 31; word_wm1_i = 31; slots_m1_i = 1;
        send_bits(32'hDEADBEEF, 32, 1'b1);
        send_bits(32'h80000001, 32, 1'b0);
        @(negedge clk);
        pop_check("R2 32b w0", 32'hDEADBEEF);
        pop_check("R2 32b w1", 32'h80000001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_widths();
        t_ext_sync();
        t_local_no_check();
        t_fifo();
        t_wide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule